// File: doc/BRIEF.md
# Event Counting Monitor

This block sits beside one processor core and counts what happens inside it. It has one dedicated cycle counter and a parameterised bank of event counters. Each event counter is programmed with a 10-bit event code that picks one line of the core's event vector. Privilege-level filter bits in the same register decide whether the counter runs at user, kernel or hypervisor level. Software reaches the block over a plain register bus made of a word address, a write strobe, write data and combinational read data.

The event counters are reached one at a time. A selector register chooses the counter, and two shared windows then read and write that counter's event type and value. The cycle counter has its own value register. Counter enables and interrupt enables are each changed through a set/clear register pair. Overflow flags are sticky and are cleared by writing ones. One interrupt line is raised for any enabled overflow. The cycle counter can advance once every 64 clocks, and it can be held while the core is in a debug-prohibited state.

Top module: `evmon_unit`

## Requirements
- R1: After reset, the control bits, counter enables, interrupt enables and overflow flags are all zero, and `irq` is low.
- R2: Word 0 is the control register. Bit 0 is the global enable, bit 3 selects divide-by-64 cycle counting, bit 4 is a stored export flag and bit 5 is the debug hold enable. Bits 1 and 2 always read 0. Bits 15:11 read as the number of event counters. Every other bit reads 0.
- R3: A control write with bit 1 set clears every event counter. A control write with bit 2 set clears the cycle counter and its prescaler. Either clear takes priority over counting in that cycle.
- R4: Word 1 is the selector. Word 2 is the event type and word 3 is the value of the selected event counter. A selector value of at least the counter count makes words 2 and 3 read 0 and makes writes to them have no effect.
- R5: The event type keeps only bits 31, 30, 27 and 9:0, so a write of all ones reads back 0xC80003FF. A code below the event-vector width counts the event line of that number. Code 0x11 counts every clock.
- R6: A counter changes only when the global enable and its own enable bit are both set. An event counter also needs its selected event to be high in that clock.
- R7: The privilege input is 0 for user, 1 for kernel, 2 for hypervisor and 3 for other. Type bit 30 blocks user counting, bit 31 blocks kernel counting, hypervisor counts only when bit 27 is set, and level 3 never counts.
- R8: Word 4 is the cycle counter value. Words 5/6 set/clear the counter enables and words 7/8 set/clear the interrupt enables. Each of these four words reads back the current mask. Bit n is event counter n and bit 31 is the cycle counter. Zero bits in a write leave the mask unchanged.
- R9: A counter that steps from all ones to zero sets its overflow flag in word 9. Word 9 reads the flags. Writing ones to word 9 clears only those flags, and a new overflow in the same clock wins over the clear.
- R10: `irq` is high exactly while some overflow flag and its interrupt enable bit are both set.
- R11: With control bit 3 set, the cycle counter advances on every 64th enabled clock after a cycle-counter clear.
- R12: With control bit 5 set and `dbg_hold` high, the cycle counter holds its value.
- R13: A write to word 10 adds one to every enabled event counter whose code is 0x00 and whose bit is set in the written data. Counters with other codes are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 4 | Register word address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the word at reg_addr |
| ev_in | input | EV_W | Event lines from the core |
| priv_lvl | input | 2 | Current privilege level |
| dbg_hold | input | 1 | Core is in a debug-prohibited state |
| irq | output | 1 | Shared overflow interrupt |

## Verification
Most internal faults show up at the ports within one or two clocks. A wrong enable, filter or event-code decode shows as a count that differs from the number of event pulses driven. A corrupt overflow flag or mask shows on `irq` in the clock after the wrap. Prescaler faults are slower and only become visible once 64 enabled clocks have passed since a cycle-counter clear, so the divider is checked at both sides of that edge. A stray write through an out-of-range selector shows only when a real counter is read back afterwards.

// File: rtl/evmon_pkg.sv
`timescale 1ns/1ps
package evmon_pkg;
   typedef enum logic [3:0] {
      A_CTRL = 4'd0, A_SEL = 4'd1, A_TYPE = 4'd2, A_VAL = 4'd3,
      A_CYC  = 4'd4, A_ENS = 4'd5, A_ENC  = 4'd6, A_IES = 4'd7,
      A_IEC  = 4'd8, A_OVF = 4'd9, A_SWI  = 4'd10
   } reg_addr_e;

   localparam logic [31:0] TYPE_KEEP = 32'hC800_03FF;
   localparam logic [9:0]  CODE_SOFT = 10'h000;
   localparam logic [9:0]  CODE_CLK  = 10'h011;
   localparam int          CYC_BIT   = 31;
   localparam int          NO_KRN    = 31;
   localparam int          NO_USR    = 30;
   localparam int          YES_HYP   = 27;

   // privilege filter: 0 user, 1 kernel, 2 hypervisor, 3 never counted
   function automatic logic level_ok(input logic [31:0] t, input logic [1:0] lvl);
      case (lvl)
         2'd0:    level_ok = !t[NO_USR];
         2'd1:    level_ok = !t[NO_KRN];
         2'd2:    level_ok = t[YES_HYP];
         default: level_ok = 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/evmon_evctr.sv
`timescale 1ns/1ps
module evmon_evctr
   import evmon_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int EV_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [EV_W-1:0]  ev_vec,
   input  logic [1:0]       priv,
   input  logic             type_we,
   input  logic             val_we,
   input  logic [31:0]      wdata,
   input  logic             zero,
   input  logic             soft_hit,
   output logic [31:0]      type_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             wrap
);
   localparam int IDX_W = (EV_W > 1) ? $clog2(EV_W) : 1;

   logic [9:0] code;
   logic       line, step;

   assign code = type_q[9:0];

   always_comb begin
      line = 1'b0;
      if (code == CODE_CLK)
         line = 1'b1;
      else if (code != CODE_SOFT && 32'(code) < EV_W)
         line = ev_vec[code[IDX_W-1:0]];
   end

   assign step = run & ((line & level_ok(type_q, priv)) | ((code == CODE_SOFT) & soft_hit));
   assign wrap = step & !zero & !val_we & (&cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         type_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (type_we) type_q <= wdata & TYPE_KEEP;
         if (zero)        cnt_q <= '0;
         else if (val_we) cnt_q <= wdata[CNT_W-1:0];
         else if (step)   cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/evmon_cyccnt.sv
`timescale 1ns/1ps
module evmon_cyccnt #(
   parameter int CNT_W    = 32,
   parameter int DIV_LOG2 = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             div_en,
   input  logic             zero,
   input  logic             val_we,
   input  logic [31:0]      wdata,
   output logic [CNT_W-1:0] cnt_q,
   output logic             wrap
);
   logic tick;

   generate
      if (DIV_LOG2 > 0) begin : g_div
         logic [DIV_LOG2-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              pre_q <= '0;
            else if (zero || val_we) pre_q <= '0;
            else if (run && div_en)  pre_q <= pre_q + 1'b1;
         end
         assign tick = run & (!div_en | (&pre_q));
      end else begin : g_nodiv
         assign tick = run;
      end
   endgenerate

   assign wrap = tick & !zero & !val_we & (&cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (zero)   cnt_q <= '0;
      else if (val_we) cnt_q <= wdata[CNT_W-1:0];
      else if (tick)   cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/evmon_unit.sv
`timescale 1ns/1ps
module evmon_unit
   import evmon_pkg::*;
#(
   parameter int NUM_CTR  = 4,
   parameter int CNT_W    = 32,
   parameter int EV_W     = 32,
   parameter int DIV_LOG2 = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [3:0]      reg_addr,
   input  logic            reg_we,
   input  logic [31:0]     reg_wdata,
   output logic [31:0]     reg_rdata,
   input  logic [EV_W-1:0] ev_in,
   input  logic [1:0]      priv_lvl,
   input  logic            dbg_hold,
   output logic            irq
);
   localparam int SEL_W = 5;
   localparam logic [31:0] IMPL = (32'd1 << CYC_BIT) | ((32'd1 << NUM_CTR) - 32'd1);

   generate
      if (NUM_CTR < 1 || NUM_CTR > 31) begin : g_bad_n
         $error("NUM_CTR must be 1..31");
      end
      if (CNT_W < 8 || CNT_W > 32) begin : g_bad_w
         $error("CNT_W must be 8..32");
      end
      if (EV_W < 2 || EV_W > 1024) begin : g_bad_ev
         $error("EV_W must be 2..1024");
      end
   endgenerate

   logic [5:0]       ctrl_q;
   logic [SEL_W-1:0] sel_q;
   logic [31:0]      en_q, ie_q, ovf_q, wraps;
   logic             sel_ok, zero_ev, zero_cyc, cyc_run, cyc_wrap;
   logic [CNT_W-1:0] cyc_cnt;
   logic [CNT_W-1:0] cnt_arr  [NUM_CTR];
   logic [31:0]      type_arr [NUM_CTR];
   logic [NUM_CTR-1:0] ev_wrap;

   function automatic logic wr_at(input reg_addr_e a);
      return reg_we && (reg_addr == a);
   endfunction

   assign sel_ok   = 32'(sel_q) < NUM_CTR;
   assign zero_ev  = wr_at(A_CTRL) & reg_wdata[1];
   assign zero_cyc = wr_at(A_CTRL) & reg_wdata[2];
   assign cyc_run  = ctrl_q[0] & en_q[CYC_BIT] & !(ctrl_q[5] & dbg_hold);

   for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
      evmon_evctr #(.CNT_W(CNT_W), .EV_W(EV_W)) i_ctr (
         .clk      (clk),
         .rst_n    (rst_n),
         .run      (ctrl_q[0] & en_q[i]),
         .ev_vec   (ev_in),
         .priv     (priv_lvl),
         .type_we  (wr_at(A_TYPE) && 32'(sel_q) == i),
         .val_we   (wr_at(A_VAL) && 32'(sel_q) == i),
         .wdata    (reg_wdata),
         .zero     (zero_ev),
         .soft_hit (wr_at(A_SWI) & reg_wdata[i]),
         .type_q   (type_arr[i]),
         .cnt_q    (cnt_arr[i]),
         .wrap     (ev_wrap[i])
      );
   end

   evmon_cyccnt #(.CNT_W(CNT_W), .DIV_LOG2(DIV_LOG2)) i_cyc (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (cyc_run),
      .div_en (ctrl_q[3]),
      .zero   (zero_cyc),
      .val_we (wr_at(A_CYC)),
      .wdata  (reg_wdata),
      .cnt_q  (cyc_cnt),
      .wrap   (cyc_wrap)
   );

   always_comb begin
      wraps = '0;
      wraps[NUM_CTR-1:0] = ev_wrap;
      wraps[CYC_BIT] = cyc_wrap;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         sel_q  <= '0;
         en_q   <= '0;
         ie_q   <= '0;
         ovf_q  <= '0;
      end else begin
         if (wr_at(A_CTRL)) ctrl_q <= reg_wdata[5:0] & 6'b111001;
         if (wr_at(A_SEL))  sel_q  <= reg_wdata[SEL_W-1:0];
         if (wr_at(A_ENS))  en_q   <= en_q | (reg_wdata & IMPL);
         if (wr_at(A_ENC))  en_q   <= en_q & ~reg_wdata;
         if (wr_at(A_IES))  ie_q   <= ie_q | (reg_wdata & IMPL);
         if (wr_at(A_IEC))  ie_q   <= ie_q & ~reg_wdata;
         ovf_q <= (ovf_q & ~(wr_at(A_OVF) ? reg_wdata : 32'd0)) | wraps;
      end
   end

   logic [CNT_W-1:0] sel_cnt;
   logic [31:0]      sel_type;
   always_comb begin
      sel_cnt  = '0;
      sel_type = '0;
      for (int i = 0; i < NUM_CTR; i++) begin
         if (32'(sel_q) == i) begin
            sel_cnt  = cnt_arr[i];
            sel_type = type_arr[i];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL: reg_rdata = {16'd0, 5'(NUM_CTR), 5'd0, ctrl_q};
         A_SEL:  reg_rdata = 32'(sel_q);
         A_TYPE: reg_rdata = sel_ok ? sel_type : 32'd0;
         A_VAL:  reg_rdata = sel_ok ? 32'(sel_cnt) : 32'd0;
         A_CYC:  reg_rdata = 32'(cyc_cnt);
         A_ENS, A_ENC: reg_rdata = en_q;
         A_IES, A_IEC: reg_rdata = ie_q;
         A_OVF:  reg_rdata = ovf_q;
         default: reg_rdata = '0;
      endcase
   end

   assign irq = |(ovf_q & ie_q);
endmodule

// File: rtl/evmon_chk.sv
`timescale 1ns/1ps
module evmon_chk
   import evmon_pkg::*;
#(
   parameter int NUM_CTR = 4,
   parameter int CNT_W   = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [3:0]       reg_addr,
   input logic             reg_we,
   input logic [31:0]      reg_wdata,
   input logic [31:0]      reg_rdata,
   input logic             irq,
   input logic             ctrl_en,
   input logic [31:0]      ie,
   input logic [31:0]      ovf,
   input logic [4:0]       sel,
   input logic [CNT_W-1:0] cyc_cnt,
   input logic             cyc_wrap
);
   assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ie != 32'd0) && (ovf != 32'd0));

   assert_wrap_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_wrap |=> ovf[31]);

   assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ovf[31] && !(reg_we && reg_addr == A_OVF && reg_wdata[31]) |=> ovf[31]);

   assert_cyc_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_en && !reg_we |=> $stable(cyc_cnt));

   assert_sel_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_VAL || reg_addr == A_TYPE) && 32'(sel) >= NUM_CTR |-> reg_rdata == 32'd0);

   assert_ctrl_ro_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_addr == A_CTRL |-> reg_rdata[15:11] == 5'(NUM_CTR) && reg_rdata[2:1] == 2'd0);
endmodule

bind evmon_unit evmon_chk #(.NUM_CTR(NUM_CTR), .CNT_W(CNT_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_we    (reg_we),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .irq       (irq),
   .ctrl_en   (ctrl_q[0]),
   .ie        (ie_q),
   .ovf       (ovf_q),
   .sel       (sel_q),
   .cyc_cnt   (cyc_cnt),
   .cyc_wrap  (cyc_wrap)
);

// File: tb/test_evmon_unit.sv
`timescale 1ns/1ps
module test_evmon_unit;
   localparam int CLK_NS = 10;
   localparam int N      = 4;
   localparam int EVW    = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [3:0]      reg_addr = '0;
   logic            reg_we = 1'b0;
   logic [31:0]     reg_wdata = '0;
   logic [31:0]     reg_rdata;
   logic [EVW-1:0]  ev_in = '0;
   logic [1:0]      priv_lvl = 2'd0;
   logic            dbg_hold = 1'b0;
   logic            irq;

   evmon_unit #(.NUM_CTR(N), .EV_W(EVW)) i_evmon_unit (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_in(ev_in),
      .priv_lvl(priv_lvl), .dbg_hold(dbg_hold), .irq(irq)
   );

   always #(CLK_NS/2) clk = ~clk;

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       tag;
   } sb_item_t;

   sb_item_t sb_q[$];
   event     smp_ev;
   int       checks = 0;
   int       errors = 0;
   bit       done = 1'b0;

   // monitor: pops the expected item and compares with what the design shows
   initial begin
      forever begin
         @(smp_ev);
         while (sb_q.size() > 0) begin
            sb_item_t it;
            logic [31:0] got;
            it  = sb_q.pop_front();
            got = it.is_irq ? {31'd0, irq} : reg_rdata;
            checks++;
            if (got !== it.exp) begin
               errors++;
               $display("FAIL %s: got 0x%08h expected 0x%08h", it.tag, got, it.exp);
            end
         end
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(posedge clk);
      #1 reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
      sb_item_t it;
      @(negedge clk);
      reg_addr = a;
      #1;
      it.is_irq = 1'b0; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      -> smp_ev;
   endtask

   task automatic chk_irq(input logic e, input string tag);
      sb_item_t it;
      @(negedge clk);
      #1;
      it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
      sb_q.push_back(it);
      -> smp_ev;
   endtask

   task automatic pulse(input int b, input int n);
      @(negedge clk);
      ev_in[b] = 1'b1;
      repeat (n) @(negedge clk);
      ev_in[b] = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(0, 32'h0000_2000, "R1 ctrl");
      rd(5, 32'h0, "R1 enables");
      rd(7, 32'h0, "R1 irq enables");
      rd(9, 32'h0, "R1 overflow");
      chk_irq(1'b0, "R1 irq");

      // R2 control layout
      wr(0, 32'hFFFF_FFFF);
      rd(0, 32'h0000_2039, "R2 ctrl all ones");
      wr(0, 32'h0);
      rd(0, 32'h0000_2000, "R2 ctrl cleared");

      // R4 / R5 selector and type
      wr(1, 1);
      wr(2, 32'hFFFF_FFFF);
      rd(2, 32'hC800_03FF, "R5 type mask");
      wr(2, 32'h0000_0005);
      wr(3, 32'd10);
      rd(3, 32'd10, "R4 value via selector");
      wr(1, 2);
      rd(3, 32'd0, "R4 other counter");
      wr(1, 7);
      wr(3, 32'h55);
      rd(3, 32'd0, "R4 out of range value");
      rd(2, 32'd0, "R4 out of range type");
      wr(1, 1);
      rd(3, 32'd10, "R4 ignored write");

      // R8 enable pair, R6 gating
      wr(5, 32'h8000_0002);
      rd(5, 32'h8000_0002, "R8 enable set");
      wr(6, 32'h0);
      rd(6, 32'h8000_0002, "R8 zero clear no effect");
      pulse(5, 3);
      rd(3, 32'd10, "R6 global off");
      wr(0, 32'h1);
      pulse(5, 3);
      rd(3, 32'd13, "R5 R6 event counting");
      wr(6, 32'h2);
      pulse(5, 3);
      rd(3, 32'd13, "R6 own enable off");

      // R8 cycle counter value
      wr(4, 32'd100);
      rd(4, 32'd100, "R8 cycle write");
      rd(4, 32'd101, "R8 cycle counts");

      // R11 divide by 64
      wr(0, 32'hD);
      repeat (63) @(posedge clk);
      rd(4, 32'd0, "R11 before 64th");
      rd(4, 32'd1, "R11 at 64th");

      // R12 debug hold
      dbg_hold = 1'b1;
      wr(0, 32'h25);
      repeat (5) @(posedge clk);
      rd(4, 32'd0, "R12 held");
      wr(0, 32'h5);
      rd(4, 32'd0, "R3 cycle clear");
      rd(4, 32'd1, "R12 hold released");
      dbg_hold = 1'b0;

      // R3 event clear
      wr(0, 32'h3);
      rd(3, 32'd0, "R3 event clear");
      wr(6, 32'h8000_0000);

      // R7 privilege filter
      wr(2, 32'h4000_0005);
      wr(5, 32'h2);
      priv_lvl = 2'd0;
      pulse(5, 2);
      rd(3, 32'd0, "R7 user excluded");
      priv_lvl = 2'd1;
      pulse(5, 2);
      rd(3, 32'd2, "R7 kernel counts");
      wr(2, 32'h8000_0005);
      pulse(5, 1);
      rd(3, 32'd2, "R7 kernel excluded");
      priv_lvl = 2'd2;
      pulse(5, 1);
      rd(3, 32'd2, "R7 hyp not included");
      wr(2, 32'h0800_0005);
      pulse(5, 1);
      rd(3, 32'd3, "R7 hyp included");
      priv_lvl = 2'd3;
      pulse(5, 1);
      rd(3, 32'd3, "R7 level 3");
      priv_lvl = 2'd0;
      wr(6, 32'h2);

      // R5 clock code
      wr(1, 2);
      wr(2, 32'h11);
      wr(5, 32'h4);
      wr(3, 32'd0);
      rd(3, 32'd0, "R5 clock code start");
      rd(3, 32'd1, "R5 clock code step");
      wr(6, 32'h4);

      // R9 / R10 overflow and interrupt
      wr(1, 3);
      wr(2, 32'h6);
      wr(3, 32'hFFFF_FFFE);
      wr(5, 32'h8);
      wr(7, 32'h8);
      pulse(6, 1);
      rd(3, 32'hFFFF_FFFF, "R9 before wrap");
      rd(9, 32'h0, "R9 no flag yet");
      chk_irq(1'b0, "R10 no irq yet");
      pulse(6, 1);
      rd(3, 32'h0, "R9 wrapped");
      rd(9, 32'h8, "R9 flag set");
      chk_irq(1'b1, "R10 irq raised");
      wr(9, 32'h1);
      rd(9, 32'h8, "R9 other bit clear");
      wr(9, 32'h8);
      rd(9, 32'h0, "R9 cleared");
      chk_irq(1'b0, "R10 irq dropped");
      wr(8, 32'h8);
      rd(7, 32'h0, "R8 irq enable clear");
      wr(3, 32'hFFFF_FFFF);
      pulse(6, 1);
      rd(9, 32'h8, "R9 flag without enable");
      chk_irq(1'b0, "R10 masked");
      wr(7, 32'h8);
      chk_irq(1'b1, "R10 unmasked");
      wr(9, 32'h8);
      chk_irq(1'b0, "R10 cleared again");

      // R13 software increment
      wr(1, 0);
      wr(3, 32'd5);
      wr(5, 32'h1);
      wr(10, 32'h1);
      rd(3, 32'd6, "R13 soft step");
      wr(10, 32'h2);
      rd(3, 32'd6, "R13 other bit");
      wr(1, 1);
      rd(3, 32'd3, "R13 non-soft code untouched");
      wr(1, 0);
      wr(6, 32'h1);
      wr(10, 32'h1);
      rd(3, 32'd6, "R13 disabled");

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule